// File: doc/BRIEF.md
# Six-Channel Buffered Pulse-Width Modulator

This block generates six independent pulse-width modulated outputs, each set up through a small word-addressed register window. Software places a period and a first-phase length, both counts of clock cycles, into holding registers. It then sets a commit bit to hand them to the channel. A channel that is already running adopts the committed values only when its counter wraps to the start of a new period. A running channel therefore never produces a shortened or stretched pulse while it is being reconfigured.

Each period begins with a first phase whose output level is set by a lead-level bit. The output holds that level for the programmed number of cycles and then takes the opposite level until the period ends. A first-phase length of zero silences the channel: the output stays low. A period of zero halts the channel.

Channel start-up follows a fixed order:
1. Write the control register, the period and the first-phase length.
2. Write the control register with the commit bit set.
3. Make a last, separate control write with the run bit set.

The bus is a plain single-cycle interface. A write is taken on the clock edge that sees the write enable. Read data is a combinational function of the address.

Top module: `pwm_bank`

## Requirements
- R1: Channel n (0 to 5) occupies byte addresses n*0x20 upward: control at +0x00, period at +0x08, first-phase length at +0x0C. Control bit 0 is run, bit 5 is continuous mode and bit 8 is the lead level. A read returns the last value written to that register, with all control bits other than 0, 5 and 8 reading 0.
- R2: A control write with bit 2 (commit) set copies the channel's held period, held first-phase length and the lead bit of that same write into a pending stage. Bit 2 always reads back 0. Period, first-phase length and lead changes that are not committed do not affect the output.
- R3: While a channel is running, pending values become active on the edge where its counter wraps, and never in mid-period. While a channel is not running, pending values become active on the next clock edge.
- R4: A running channel counts 0, 1, ..., period-1 and then returns to 0. The output is in its first phase while count < length. With lead 1 the first phase is high and the rest of the period is low; with lead 0 the first phase is low and the rest is high.
- R5: A first-phase length greater than or equal to the period keeps the output at its first-phase level for the whole period.
- R6: An active first-phase length of 0 holds the output low, whatever the lead bit.
- R7: An active period of 0 holds the counter at 0 and the output low.
- R8: Setting run starts the count at 0 on the following cycle. Clearing run returns the counter to 0 and drives the output low from the next cycle.
- R9: Addresses inside the 0xB0-byte window that hold no register read 0. Writes to those addresses, and any access at or above 0xB0, change no state.
- R10: Reset clears every register, and all outputs are low after reset.
- R11: The six channels run independently; programming one channel leaves the others' outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write enable, taken on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 6 | One modulated output per channel |

## Verification
The assertions assume that the address and write enable are stable across each clock edge. They also assume that software alters the run bit only through explicit control writes, so every change to the active stage can be traced to a commit followed by either a wrap or an idle channel. The stimulus drives every bus signal a short time after the rising edge and issues one access per cycle. It keeps periods small so that wraps, commits that arrive mid-period and stop events all fall within a short run. The bench compares every output and every read against a behavioural model on each falling edge, and adds directed checks for silencing, zero period, first-phase lengths that meet or exceed the period, and writes outside the map.

// File: rtl/pwm_bank_pkg.sv
// Package: shared field positions and register offsets of the PWM bank.
// Assumes byte addressing with 32-bit registers on word boundaries.
package pwm_bank_pkg;
    localparam int CTL_RUN_BIT    = 0;
    localparam int CTL_COMMIT_BIT = 2;
    localparam int CTL_CONT_BIT   = 5;
    localparam int CTL_LEAD_BIT   = 8;

    localparam int OFF_CTL  = 'h00;
    localparam int OFF_PER  = 'h08;
    localparam int OFF_LEN  = 'h0C;
endpackage

// File: rtl/pwm_bank_regs.sv
// Module: register file of the PWM bank. Decodes byte addresses into a
// channel index and an offset, keeps the holding copy of each channel's
// control, period and first-phase length, produces a one-cycle commit strobe
// and serves combinational reads.
// Assumes: single-cycle writes. Accesses at or above WINDOW are dropped.
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH    = 6,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int CH_STRIDE = 32,
    parameter int WINDOW    = 176
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_we,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    output logic [NUM_CH-1:0]              run_q,
    output logic [NUM_CH-1:0]              commit_p,
    output logic [NUM_CH-1:0]              commit_lead,
    output logic [NUM_CH-1:0][DATA_W-1:0]  per_q,
    output logic [NUM_CH-1:0][DATA_W-1:0]  len_q
);
    localparam int CH_SHIFT = $clog2(CH_STRIDE);
    localparam int IDX_W    = ADDR_W - CH_SHIFT;
    localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(WINDOW);

    logic                   in_win;
    logic [IDX_W-1:0]       ch_idx;
    logic [CH_SHIFT-1:0]    off;
    logic [NUM_CH-1:0]      sel;
    logic [NUM_CH-1:0]      cont_q;
    logic [NUM_CH-1:0]      lead_q;

    // Split the address into a window flag, a channel index and an offset.
    always_comb begin
        in_win = (bus_addr < WIN_END);
        ch_idx = bus_addr[ADDR_W-1:CH_SHIFT];
        off    = bus_addr[CH_SHIFT-1:0];
    end

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            logic wr_ctl, wr_per, wr_len;

            // Select this channel and pick the register being written.
            always_comb begin
                sel[c] = in_win && (ch_idx == IDX_W'(c));
                wr_ctl = bus_we && sel[c] && (off == CH_SHIFT'(OFF_CTL));
                wr_per = bus_we && sel[c] && (off == CH_SHIFT'(OFF_PER));
                wr_len = bus_we && sel[c] && (off == CH_SHIFT'(OFF_LEN));
            end

            // Holding registers and the commit strobe of one channel.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    run_q[c]       <= 1'b0;
                    cont_q[c]      <= 1'b0;
                    lead_q[c]      <= 1'b0;
                    per_q[c]       <= '0;
                    len_q[c]       <= '0;
                    commit_p[c]    <= 1'b0;
                    commit_lead[c] <= 1'b0;
                end else begin
                    commit_p[c] <= 1'b0;
                    if (wr_ctl) begin
                        run_q[c]  <= bus_wdata[CTL_RUN_BIT];
                        cont_q[c] <= bus_wdata[CTL_CONT_BIT];
                        lead_q[c] <= bus_wdata[CTL_LEAD_BIT];
                        if (bus_wdata[CTL_COMMIT_BIT]) begin
                            commit_p[c]    <= 1'b1;
                            commit_lead[c] <= bus_wdata[CTL_LEAD_BIT];
                        end
                    end
                    if (wr_per) per_q[c] <= bus_wdata;
                    if (wr_len) len_q[c] <= bus_wdata;
                end
            end
        end
    endgenerate

    // Read mux: holding values of the addressed register, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (sel[k]) begin
                if (off == CH_SHIFT'(OFF_CTL)) begin
                    bus_rdata[CTL_RUN_BIT]  = run_q[k];
                    bus_rdata[CTL_CONT_BIT] = cont_q[k];
                    bus_rdata[CTL_LEAD_BIT] = lead_q[k];
                end else if (off == CH_SHIFT'(OFF_PER)) begin
                    bus_rdata = per_q[k];
                end else if (off == CH_SHIFT'(OFF_LEN)) begin
                    bus_rdata = len_q[k];
                end
            end
        end
    end

    // R9: a write outside the window leaves every holding register unchanged.
    assert_oob_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !in_win) |=> ($stable(per_q) && $stable(len_q) && $stable(run_q)
                                 && $stable(lead_q) && $stable(cont_q)));

    // R2: the commit strobe lasts exactly one cycle per control write.
    assert_commit_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_p != '0 && !bus_we) |=> (commit_p == '0));
endmodule

// File: rtl/pwm_bank_chan.sv
// Module: one PWM channel. It holds the pending stage filled by a commit,
// the active stage used by the counter, and the period counter. It decodes
// the output from the count and the active values.
// Assumes: commit_i is a one-cycle strobe; per_i/len_i are the holding copies.
module pwm_bank_chan #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              commit_i,
    input  logic              lead_i,
    input  logic [DATA_W-1:0] per_i,
    input  logic [DATA_W-1:0] len_i,
    output logic              pwm_o
);
    logic              pend_v;
    logic              pend_lead;
    logic [DATA_W-1:0] pend_per, pend_len;
    logic              act_lead;
    logic [DATA_W-1:0] act_per, act_len;
    logic [DATA_W-1:0] cnt;
    logic              running, wrap, xfer, first;

    // Counter state and the moment the pending values may move in.
    always_comb begin
        running = run_i && (act_per != '0);
        wrap    = running && (cnt == act_per - DATA_W'(1));
        xfer    = pend_v && (!running || wrap);
    end

    // Pending stage: filled by a commit and emptied by a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_lead <= 1'b0;
            pend_per  <= '0;
            pend_len  <= '0;
        end else if (commit_i) begin
            pend_v    <= 1'b1;
            pend_lead <= lead_i;
            pend_per  <= per_i;
            pend_len  <= len_i;
        end else if (xfer) begin
            pend_v    <= 1'b0;
        end
    end

    // Active stage: changes only on a wrap or while the channel is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_lead <= 1'b0;
            act_per  <= '0;
            act_len  <= '0;
        end else if (xfer) begin
            act_lead <= pend_lead;
            act_per  <= pend_per;
            act_len  <= pend_len;
        end
    end

    // Period counter: steps while running, wraps at period-1, else held at 0.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (wrap)    cnt <= '0;
        else if (running) cnt <= cnt + DATA_W'(1);
        else              cnt <= '0;
    end

    // Output decode: first phase at the lead level, then the opposite level.
    always_comb begin
        first = (cnt < act_len);
        pwm_o = running && (act_len != '0) && (act_lead ? first : !first);
    end

    // R4: a running counter that is not wrapping steps by one.
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap) |=> (cnt == $past(cnt) + DATA_W'(1)));

    // R3: the active period never changes inside a running period.
    assert_active_glitch_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap) |=> ($stable(act_per) && $stable(act_len) && $stable(act_lead)));

    // R3: on an idle channel a pending commit is consumed at the next edge.
    assert_idle_commit_applies_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_v && !running && !commit_i) |=> !pend_v);

    // R8: with run clear the counter returns to zero.
    assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt == '0));

    // R7: a zero active period keeps the counter at zero.
    assert_zero_period_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_per == '0 && !xfer) |=> (cnt == '0));
endmodule

// File: rtl/pwm_bank.sv
// Module: top of the six-channel buffered PWM bank. Connects the register
// file to one channel instance per output.
// Assumes: one clock domain, synchronous active-low reset.
module pwm_bank #(
    parameter int NUM_CH    = 6,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int CH_STRIDE = 32,
    parameter int WINDOW    = 176
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [NUM_CH-1:0]             run_q, commit_p, commit_lead;
    logic [NUM_CH-1:0][DATA_W-1:0] per_q, len_q;

    pwm_bank_regs #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .CH_STRIDE(CH_STRIDE), .WINDOW(WINDOW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .run_q(run_q), .commit_p(commit_p), .commit_lead(commit_lead),
        .per_q(per_q), .len_q(len_q)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_chan
            pwm_bank_chan #(.DATA_W(DATA_W)) u_chan (
                .clk(clk), .rst_n(rst_n),
                .run_i(run_q[c]), .commit_i(commit_p[c]), .lead_i(commit_lead[c]),
                .per_i(per_q[c]), .len_i(len_q[c]),
                .pwm_o(pwm_out[c])
            );
        end
    endgenerate
endmodule

// File: tb/pwm_bank_test.sv
// Bench: behavioural reference model compared on every falling edge, plus
// directed checks per requirement.
module pwm_bank_test;
    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    bit done = 0;
    string phase = "R10";

    always #10 clk = ~clk;

    pwm_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // Reference model state
    bit        m_run[NCH], m_cont[NCH], m_lead[NCH];
    bit [31:0] m_per[NCH], m_len[NCH];
    bit        m_pv[NCH], m_plead[NCH];
    bit [31:0] m_pper[NCH], m_plen[NCH];
    bit        m_alead[NCH];
    bit [31:0] m_aper[NCH], m_alen[NCH], m_cnt[NCH];

    function automatic bit [31:0] model_read(bit [7:0] a);
        int ch, off;
        if (a >= 8'hB0) return 32'h0;
        ch = int'(a) / 32;
        off = int'(a) % 32;
        if (off == 0) return (32'(m_lead[ch]) << 8) | (32'(m_cont[ch]) << 5) | 32'(m_run[ch]);
        if (off == 8) return m_per[ch];
        if (off == 12) return m_len[ch];
        return 32'h0;
    endfunction

    function automatic bit model_out(int ch);
        bit active;
        active = m_run[ch] && (m_aper[ch] != 0);
        if (!active || m_alen[ch] == 0) return 1'b0;
        if (m_alead[ch]) return (m_cnt[ch] < m_alen[ch]);
        return !(m_cnt[ch] < m_alen[ch]);
    endfunction

    // Model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_run[c] = 0; m_cont[c] = 0; m_lead[c] = 0; m_per[c] = 0; m_len[c] = 0;
                m_pv[c] = 0; m_plead[c] = 0; m_pper[c] = 0; m_plen[c] = 0;
                m_alead[c] = 0; m_aper[c] = 0; m_alen[c] = 0; m_cnt[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                automatic bit act = m_run[c] && (m_aper[c] != 0);
                automatic bit at_end = act && (m_cnt[c] == m_aper[c] - 1);
                if (m_pv[c] && (!act || at_end)) begin
                    m_aper[c] = m_pper[c]; m_alen[c] = m_plen[c]; m_alead[c] = m_plead[c];
                    m_pv[c] = 0;
                end
                if (!act || at_end) m_cnt[c] = 0;
                else m_cnt[c] = m_cnt[c] + 1;
            end
            if (bus_we && bus_addr < 8'hB0) begin
                automatic int ch = int'(bus_addr) / 32;
                automatic int off = int'(bus_addr) % 32;
                if (off == 0) begin
                    m_run[ch] = bus_wdata[0]; m_cont[ch] = bus_wdata[5]; m_lead[ch] = bus_wdata[8];
                    if (bus_wdata[2]) begin
                        m_pv[ch] = 1; m_pper[ch] = m_per[ch]; m_plen[ch] = m_len[ch];
                        m_plead[ch] = bus_wdata[8];
                    end
                end else if (off == 8) m_per[ch] = bus_wdata;
                else if (off == 12) m_len[ch] = bus_wdata;
            end
        end
    end

    // Compare the design against the model on every falling edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            bit [5:0] exp_out;
            bit [31:0] exp_rd;
            for (int c = 0; c < NCH; c++) exp_out[c] = model_out(c);
            exp_rd = model_read(bus_addr);
            checks += 2;
            if (pwm_out !== exp_out) begin
                errors++;
                $display("FAIL %s model pwm_out actual=%b expected=%b t=%0t", phase, pwm_out, exp_out, $time);
            end
            if (bus_rdata !== exp_rd) begin
                errors++;
                $display("FAIL %s model rdata addr=%h actual=%h expected=%h", phase, bus_addr, bus_rdata, exp_rd);
            end
        end
    end

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        @(posedge clk); #2;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #2;
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input bit [7:0] a, input bit [31:0] exp, input string req);
        @(posedge clk); #2;
        bus_addr = a;
        @(negedge clk);
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s read addr=%h actual=%h expected=%h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic out_chk(input int ch, input bit exp, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            checks++;
            if (pwm_out[ch] !== exp) begin
                errors++;
                $display("FAIL %s out[%0d] actual=%b expected=%b", req, ch, pwm_out[ch], exp);
            end
        end
    endtask

    task automatic setup(input int ch, input bit [31:0] ctl, input bit [31:0] per, input bit [31:0] len);
        bit [7:0] b;
        b = 8'(ch * 32);
        wr(b, ctl);
        wr(b + 8'h08, per);
        wr(b + 8'h0C, len);
        wr(b, ctl | 32'h4);
        wr(b, ctl | 32'h1);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        #2 cmp_on = 1;
        @(negedge clk);
        checks++;
        if (pwm_out !== 6'b0) begin
            errors++;
            $display("FAIL R10 pwm_out actual=%b expected=000000", pwm_out);
        end
        rst_n = 1'b1;
        rd_chk(8'h00, 32'h0, "R10");
        rd_chk(8'hA8, 32'h0, "R10");

        // R1/R4: channel 0, lead high, period 5, length 2
        phase = "R4";
        wr(8'h00, 32'h120);
        wr(8'h08, 32'd5);
        wr(8'h0C, 32'd2);
        wr(8'h00, 32'h124);
        rd_chk(8'h00, 32'h120, "R2");        // R2: commit bit reads 0
        wr(8'h00, 32'h121);
        rd_chk(8'h00, 32'h121, "R1");
        rd_chk(8'h08, 32'd5, "R1");
        rd_chk(8'h0C, 32'd2, "R1");
        wait_cyc(12);

        // R2: held values without commit do not change the output
        phase = "R2";
        wr(8'h08, 32'd8);
        wr(8'h0C, 32'd6);
        wait_cyc(12);

        // R3: commit on a running channel takes effect at the wrap
        phase = "R3";
        wr(8'h00, 32'h125);
        wait_cyc(20);

        // R4: lead low on channel 1
        phase = "R4";
        setup(1, 32'h020, 32'd4, 32'd1);
        wait_cyc(12);

        // R5: length beyond period keeps the first-phase level
        phase = "R5";
        setup(2, 32'h120, 32'd3, 32'd7);
        wait_cyc(1);
        out_chk(2, 1'b1, 6, "R5");

        // R6: zero length is silent even with lead low
        phase = "R6";
        setup(3, 32'h020, 32'd4, 32'd0);
        out_chk(3, 1'b0, 8, "R6");

        // R7: zero period holds output low
        phase = "R7";
        setup(4, 32'h120, 32'd0, 32'd3);
        out_chk(4, 1'b0, 8, "R7");

        // R8: clearing run on channel 1 stops it
        phase = "R8";
        wr(8'h20, 32'h020);
        out_chk(1, 1'b0, 6, "R8");
        rd_chk(8'h20, 32'h020, "R8");

        // R11: channel 5 at the top of the window, others keep running
        phase = "R11";
        setup(5, 32'h120, 32'd3, 32'd1);
        wait_cyc(9);

        // R9: unmapped reads and ignored writes
        phase = "R9";
        rd_chk(8'h04, 32'h0, "R9");
        rd_chk(8'h10, 32'h0, "R9");
        rd_chk(8'hB4, 32'h0, "R9");
        wr(8'hB8, 32'hFFFF_FFFF);
        wr(8'hA4, 32'hFFFF_FFFF);
        wr(8'hC0, 32'hFFFF_FFFF);
        rd_chk(8'hA0, 32'h121, "R9");
        rd_chk(8'hA8, 32'd3, "R9");
        rd_chk(8'hAC, 32'd1, "R9");
        wait_cyc(6);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule